// File: doc/BRIEF.md
# Sliding-Window Severely Errored Frame Detector

This block watches the results of checking DS3 framing bits. For each framing bit there is one valid strobe, and an error flag says whether that bit was wrong. The block keeps a history of the most recent framing-bit results. It raises a live condition when enough of them are in error. The window moves forward by one position on every strobe. It does not advance in fixed blocks.

The live condition feeds a sticky status bit for software. The bit sets whenever the condition is present. A status read strobe clears it. If the condition is still present at that moment, the bit stays set. Extracting the framing bits and finding frame alignment happen upstream of this block. Window length and error threshold are parameters. The defaults are 16 framing bits and 3 errors.

Top module: `sef_detect`

## Requirements
- R1: While `rst_n` is low, `sef_live` and `sef_latched` are 0 and the window holds no errors. Assertion of `rst_n` acts without waiting for a clock edge.
- R2: `sef_live` is 1 when 3 or more of the last 16 strobed flags are errors (`fbit_err`=1 with `fbit_vld`=1), and 0 otherwise. Two errors in the window are not enough.
- R3: The window advances by one entry per strobe. An error stops counting at the 16th strobe after it. `sef_live` changes in the cycle after the clock edge that samples the strobe.
- R4: A cycle with `fbit_vld`=0 leaves the window unchanged. `fbit_err` is ignored in such a cycle.
- R5: `sef_latched` is 1 in the cycle after any cycle in which `sef_live` is 1.
- R6: `stat_rd`=1 in a cycle with `sef_live`=0 makes `sef_latched` 0 in the next cycle.
- R7: `stat_rd`=1 in a cycle with `sef_live`=1 leaves `sef_latched` at 1: the set wins over the clear, so the bit relatches.
- R8: Without a read, `sef_latched` stays 1 after `sef_live` returns to 0.
- R9: `sef_latched` rises only in the cycle after one in which `sef_live` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized internally |
| fbit_vld | input | 1 | One framing-bit check result is present this cycle |
| fbit_err | input | 1 | That framing bit was in error (valid with `fbit_vld`) |
| stat_rd | input | 1 | Status read strobe; clears the latched bit |
| sef_live | output | 1 | Live condition: error count in the window is at or above the threshold |
| sef_latched | output | 1 | Sticky status bit, cleared on read, relatches if the condition persists |

## Verification
The assertions check the status bit on every cycle:
- it follows the live condition by one cycle;
- it clears on a read while the condition is absent;
- it stays set through a read while the condition is present;
- it holds without a read;
- it never rises without a cause.

They also check that the live condition is unchanged in any cycle without a strobe.

Whether the live condition matches the error count over exactly the last sixteen strobes can be seen only in the bench's scenarios, because it depends on long histories. These scenarios cover two errors versus three, an error ageing out on the sixteenth strobe, a full window of errors draining one strobe at a time, and asynchronous reset in the middle of operation.

// File: rtl/sef_pkg.sv
package sef_pkg;

  // Bits needed to hold a count from 0 to n inclusive.
  function automatic int cnt_bits(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sef_rst_sync.sv
module sef_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/sef_window.sv
module sef_window
  import sef_pkg::*;
#(
  parameter int WIN_LEN    = 16,
  parameter int ERR_THRESH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fbit_vld,
  input  logic fbit_err,
  output logic over_thresh
);

  localparam int CNT_W = cnt_bits(WIN_LEN);
  localparam logic [CNT_W-1:0] THR = CNT_W'(ERR_THRESH);

  logic [WIN_LEN-1:0] hist_q, hist_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0]   add_v, sub_v;

  always_comb begin
    add_v  = {{(CNT_W-1){1'b0}}, fbit_err};
    sub_v  = {{(CNT_W-1){1'b0}}, hist_q[WIN_LEN-1]};
    hist_d = hist_q;
    cnt_d  = cnt_q;
    if (fbit_vld) begin
      hist_d = {hist_q[WIN_LEN-2:0], fbit_err};
      cnt_d  = cnt_q + add_v - sub_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else if (fbit_vld) begin
      hist_q <= hist_d;
      cnt_q  <= cnt_d;
    end
  end

  assign over_thresh = (cnt_q >= THR);

endmodule

// File: rtl/sef_status.sv
module sef_status (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic rd,
  output logic latched
);

  logic lat_q, lat_d;

  always_comb begin
    lat_d = lat_q;
    if (rd) begin
      lat_d = 1'b0;
    end
    if (cond) begin
      lat_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
    end else begin
      lat_q <= lat_d;
    end
  end

  assign latched = lat_q;

endmodule

// File: rtl/sef_detect.sv
module sef_detect #(
  parameter int WIN_LEN    = 16,
  parameter int ERR_THRESH = 3,
  parameter int SYNC_STG   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fbit_vld,
  input  logic fbit_err,
  input  logic stat_rd,
  output logic sef_live,
  output logic sef_latched
);

  logic rst_n_int;
  logic live_w;

  sef_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sef_window #(.WIN_LEN(WIN_LEN), .ERR_THRESH(ERR_THRESH)) u_win (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .fbit_vld    (fbit_vld),
    .fbit_err    (fbit_err),
    .over_thresh (live_w)
  );

  sef_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .cond    (live_w),
    .rd      (stat_rd),
    .latched (sef_latched)
  );

  assign sef_live = live_w;

endmodule

// File: rtl/sef_detect_chk.sv
module sef_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic fbit_vld,
  input logic stat_rd,
  input logic sef_live,
  input logic sef_latched
);

  assert_reset_outputs_R1: assert property (@(posedge clk)
    !rst_n |-> (!sef_live && !sef_latched));

  assert_no_strobe_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fbit_vld |=> $stable(sef_live));

  assert_set_follows_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sef_live |=> sef_latched);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !sef_live) |=> !sef_latched);

  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && sef_live) |=> sef_latched);

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sef_latched && !stat_rd) |=> sef_latched);

  assert_rise_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sef_latched) |-> $past(sef_live));

endmodule

bind sef_detect sef_detect_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fbit_vld    (fbit_vld),
  .stat_rd     (stat_rd),
  .sef_live    (sef_live),
  .sef_latched (sef_latched)
);

// File: tb/tb_sef_detect.sv
`timescale 1ns/1ps
module tb_sef_detect;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fbit_vld = 1'b0;
  logic fbit_err = 1'b0;
  logic stat_rd = 1'b0;
  logic sef_live;
  logic sef_latched;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sef_detect dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .fbit_vld    (fbit_vld),
    .fbit_err    (fbit_err),
    .stat_rd     (stat_rd),
    .sef_live    (sef_live),
    .sef_latched (sef_latched)
  );

  // {vld, err, rd, exp_live, exp_latched}, outputs sampled after the edge
  localparam int NV = 7;
  localparam logic [4:0] VEC [NV] = '{
    5'b11000,  // R2: one error
    5'b11000,  // R2: two errors, still below threshold
    5'b01000,  // R4: err without strobe is ignored
    5'b10000,  // clean strobe
    5'b11010,  // R2: third error, live rises
    5'b00011,  // R5: latched follows live
    5'b00111   // R7: read while live keeps the bit
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic e, input logic r);
    @(negedge clk);
    fbit_vld = v; fbit_err = e; stat_rd = r;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 live in reset", sef_live, 1'b0);
    chk("R1 latched in reset", sef_latched, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][4], VEC[i][3], VEC[i][2]);
      chk($sformatf("R2 vec%0d live", i), sef_live, VEC[i][1]);
      chk($sformatf("R5 vec%0d latched", i), sef_latched, VEC[i][0]);
    end

    // R3: errors stay counted for 16 strobes; the oldest drops on the 13th clean one
    for (int k = 1; k <= 12; k++) begin
      step(1'b1, 1'b0, 1'b0);
    end
    chk("R3 live after 12 clean", sef_live, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    chk("R3 live after oldest ages out", sef_live, 1'b0);
    chk("R8 latched holds after live falls", sef_latched, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    chk("R8 latched holds idle", sef_latched, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    chk("R6 read clears", sef_latched, 1'b0);
    chk("R4 live unchanged without strobe", sef_live, 1'b0);

    // R1: async reset in mid-run
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    #1;
    rst_n = 1'b0;
    #1;
    chk("R1 async reset live", sef_live, 1'b0);
    chk("R1 async reset latched", sef_latched, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R3: full window of errors drains one per strobe
    for (int k = 0; k < 16; k++) begin
      step(1'b1, 1'b1, 1'b0);
    end
    chk("R2 full window live", sef_live, 1'b1);
    for (int k = 1; k <= 12; k++) begin
      step(1'b1, 1'b0, 1'b0);
    end
    step(1'b1, 1'b0, 1'b1);
    chk("R3 three left live", sef_live, 1'b1);
    chk("R7 read with live keeps bit", sef_latched, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    chk("R3 two left not live", sef_live, 1'b0);
    chk("R7 relatch on read", sef_latched, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    chk("R6 read clears after drain", sef_latched, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk("R9 no spurious set", sef_latched, 1'b0);

    done = 1'b1;
    finish_run();
  end

endmodule